// File: doc/BRIEF.md
# Dual-Channel Wiper and Control Register Executor

This block carries out register commands for a pair of digitally set potentiometer channels and their comparators. It holds four live registers: two 6-bit wiper positions and two 6-bit comparator control words. Behind each live register sit four stored slots. These slots stand in for non-volatile memory: a register array that keeps its contents across `rst_n`, together with a timer that models the long programming time. The front end sends one decoded command per handshake. Each command carries a 4-bit opcode, a 2-bit target field, a 2-bit slot field and a 6-bit data value. Read results leave on a response port.

The command port uses valid/ready. A command is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low in three cases: during reset, while a store is in progress, and while a read response is waiting. A read response stays valid with stable data until `rsp_ready` is high at a clock edge. The master may hold `rsp_ready` low for as long as it likes. The command port stays stalled until the response has been taken.

Top module: `dualpot_regexec`

## Requirements
- R1: While `rst_n` is low, every live register is loaded from its own slot 0. Slots are never cleared by reset. Before any store, slots hold `WIPER_INIT` (default 32) for wiper targets and `CTRL_INIT` (default 3) for control targets.
- R2: Target codes are 00 = wiper 0, 01 = wiper 1, 10 = control 0 and 11 = control 1. Opcode 1010 writes `cmd_data` into the addressed live register, and the new value is visible on the cycle after acceptance.
- R3: Opcode 1001 returns the addressed live register on `rsp_data`, with `rsp_valid` high on the cycle after acceptance.
- R4: Opcode 1100 writes `cmd_data` into the slot picked by target and slot fields. Opcode 1011 returns that slot on the response port.
- R5: Opcode 1101 copies the addressed slot into its live register. Opcode 1110 copies the live register into the addressed slot.
- R6: Opcode 0001 loads all four live registers from slot `cmd_slot` at once. Opcode 1000 copies all four live registers into slot `cmd_slot` at once. Both ignore the target field.
- R7: Each accepted store (1100, 1110, 1000) with `wp_n` high raises `busy` for exactly `BUSY_CYCLES` cycles, starting on the cycle after acceptance. `cmd_ready` stays low while `busy` is high.
- R8: With `wp_n` low, store opcodes are accepted but change no slot and start no busy window. Commands that only touch live registers are unaffected.
- R9: Opcodes outside the set above (for example 0010 and 1111) are accepted but change no register.
- R10: A pending response keeps `rsp_valid` high and `rsp_data` stable until `rsp_ready` is high, and `cmd_ready` stays low while `rsp_valid` is high.
- R11: For each comparator, control bit 0 drives `comp_pwr`, bit 1 drives `comp_oe` and bit 2 drives `comp_latch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; triggers slot-0 recall |
| wp_n | input | 1 | Write protect, low blocks stores |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high with valid |
| cmd_op | input | 4 | Opcode |
| cmd_tgt | input | 2 | Target select (wiper/control) |
| cmd_slot | input | 2 | Stored slot select |
| cmd_data | input | 6 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | 6 | Read response data |
| wiper_pos | output | 12 | Wiper positions, channel 0 in the low 6 bits |
| ctrl_word | output | 12 | Control words, channel 0 in the low 6 bits |
| comp_pwr | output | 2 | Comparator power bit per channel |
| comp_oe | output | 2 | Comparator output enable per channel |
| comp_latch | output | 2 | Comparator latch bit per channel |
| busy | output | 1 | Store in progress |

## Verification
Every live-register change and every read response is due one clock after the acceptance edge, so the bench samples on the falling edge that directly follows acceptance. The store window is measured by counting the falling-edge samples on which `busy` is high, and that count must equal `BUSY_CYCLES`. Checks of suppressed stores read the protected slot back through opcode 1011 once the suppressed command has completed. Recall is checked on the first falling edge after `rst_n` rises.

// File: rtl/potreg_pkg.sv
package potreg_pkg;

  // Opcodes understood by the executor
  localparam logic [3:0] OP_GLOAD   = 4'b0001;
  localparam logic [3:0] OP_GSTORE  = 4'b1000;
  localparam logic [3:0] OP_LIVE_RD = 4'b1001;
  localparam logic [3:0] OP_LIVE_WR = 4'b1010;
  localparam logic [3:0] OP_SLOT_RD = 4'b1011;
  localparam logic [3:0] OP_SLOT_WR = 4'b1100;
  localparam logic [3:0] OP_LOAD    = 4'b1101;
  localparam logic [3:0] OP_STORE   = 4'b1110;

  // Control word bit positions
  localparam int CB_PWR   = 0;
  localparam int CB_OE    = 1;
  localparam int CB_LATCH = 2;

  function automatic logic op_is_store(input logic [3:0] op);
    return (op == OP_SLOT_WR) || (op == OP_STORE) || (op == OP_GSTORE);
  endfunction

  function automatic logic op_is_known(input logic [3:0] op);
    return (op == OP_GLOAD) || (op == OP_GSTORE) || (op == OP_LIVE_RD) ||
           (op == OP_LIVE_WR) || (op == OP_SLOT_RD) || (op == OP_SLOT_WR) ||
           (op == OP_LOAD) || (op == OP_STORE);
  endfunction

endpackage

// File: rtl/potreg_nv_cell.sv
// One retained storage word: no reset, holds its contents across rst_n.
module potreg_nv_cell #(
  parameter int DW = 6,
  parameter logic [DW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          we,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  logic [DW-1:0] mem_q = INIT;

  always_ff @(posedge clk) begin
    if (we) mem_q <= d;
  end

  assign q = mem_q;

endmodule

// File: rtl/potreg_nv_bank.sv
// Retained slot array: NT targets, each with NUM_SLOT words.
module potreg_nv_bank #(
  parameter int DW        = 6,
  parameter int NT        = 4,
  parameter int NUM_SLOT  = 4,
  parameter int NUM_WIPER = 2,
  parameter logic [DW-1:0] WIPER_INIT = '0,
  parameter logic [DW-1:0] CTRL_INIT  = '0,
  localparam int SW = $clog2(NUM_SLOT)
) (
  input  logic                                 clk,
  input  logic [NT-1:0]                        we,
  input  logic [SW-1:0]                        idx,
  input  logic [NT-1:0][DW-1:0]                wdata,
  output logic [NT-1:0][NUM_SLOT-1:0][DW-1:0]  rdata
);

  for (genvar t = 0; t < NT; t++) begin : g_tgt
    localparam logic [DW-1:0] CELL_INIT = (t < NUM_WIPER) ? WIPER_INIT : CTRL_INIT;
    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
      potreg_nv_cell #(
        .DW   (DW),
        .INIT (CELL_INIT)
      ) u_cell (
        .clk (clk),
        .we  (we[t] && (idx == SW'(s))),
        .d   (wdata[t]),
        .q   (rdata[t][s])
      );
    end
  end

endmodule

// File: rtl/potreg_store_timer.sv
// Models the programming time of a store: busy for CYCLES clocks after start.
module potreg_store_timer #(
  parameter int CYCLES = 500000,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

endmodule

// File: rtl/dualpot_regexec.sv
module dualpot_regexec
  import potreg_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int DW          = 6,
  parameter int NUM_SLOT    = 4,
  parameter int BUSY_CYCLES = 500000,
  parameter logic [DW-1:0] WIPER_INIT = DW'(32),
  parameter logic [DW-1:0] CTRL_INIT  = DW'(3),
  localparam int NT = 2 * NUM_CH,
  localparam int TW = $clog2(NT),
  localparam int SW = $clog2(NUM_SLOT)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wp_n,
  input  logic                         cmd_valid,
  output logic                         cmd_ready,
  input  logic [3:0]                   cmd_op,
  input  logic [TW-1:0]                cmd_tgt,
  input  logic [SW-1:0]                cmd_slot,
  input  logic [DW-1:0]                cmd_data,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [DW-1:0]                rsp_data,
  output logic [NUM_CH-1:0][DW-1:0]    wiper_pos,
  output logic [NUM_CH-1:0][DW-1:0]    ctrl_word,
  output logic [NUM_CH-1:0]            comp_pwr,
  output logic [NUM_CH-1:0]            comp_oe,
  output logic [NUM_CH-1:0]            comp_latch,
  output logic                         busy
);

  // Live registers: targets 0..NUM_CH-1 are wipers, the rest control words
  logic [NT-1:0][DW-1:0]               vol_q;
  logic [NT-1:0][DW-1:0]               vol_d;
  logic [NT-1:0]                       vol_we;

  logic [NT-1:0]                       nv_we;
  logic [NT-1:0][DW-1:0]               nv_wd;
  logic [NT-1:0][NUM_SLOT-1:0][DW-1:0] nv_rd;

  logic          acc;
  logic          rsp_load;
  logic [DW-1:0] rsp_d;
  logic          store_go;
  logic          busy_w;

  assign cmd_ready = rst_n && !busy_w && !rsp_valid;
  assign acc       = cmd_valid && cmd_ready;
  assign store_go  = |nv_we;

  // Command decode: one command per accepted handshake
  always_comb begin
    vol_we   = '0;
    vol_d    = '0;
    nv_we    = '0;
    nv_wd    = '0;
    rsp_load = 1'b0;
    rsp_d    = '0;
    if (acc) begin
      case (cmd_op)
        OP_LIVE_WR: begin
          vol_we[cmd_tgt] = 1'b1;
          vol_d[cmd_tgt]  = cmd_data;
        end
        OP_LIVE_RD: begin
          rsp_load = 1'b1;
          rsp_d    = vol_q[cmd_tgt];
        end
        OP_SLOT_RD: begin
          rsp_load = 1'b1;
          rsp_d    = nv_rd[cmd_tgt][cmd_slot];
        end
        OP_SLOT_WR: begin
          nv_we[cmd_tgt] = wp_n;
          nv_wd[cmd_tgt] = cmd_data;
        end
        OP_LOAD: begin
          vol_we[cmd_tgt] = 1'b1;
          vol_d[cmd_tgt]  = nv_rd[cmd_tgt][cmd_slot];
        end
        OP_STORE: begin
          nv_we[cmd_tgt] = wp_n;
          nv_wd[cmd_tgt] = vol_q[cmd_tgt];
        end
        OP_GLOAD: begin
          for (int t = 0; t < NT; t++) begin
            vol_we[t] = 1'b1;
            vol_d[t]  = nv_rd[t][cmd_slot];
          end
        end
        OP_GSTORE: begin
          for (int t = 0; t < NT; t++) begin
            nv_we[t] = wp_n;
            nv_wd[t] = vol_q[t];
          end
        end
        default: ;
      endcase
    end
  end

  // Live registers with slot-0 recall while in reset
  always_ff @(posedge clk) begin
    for (int t = 0; t < NT; t++) begin
      if (!rst_n)         vol_q[t] <= nv_rd[t][0];
      else if (vol_we[t]) vol_q[t] <= vol_d[t];
    end
  end

  // Read response register with back-pressure
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rsp_load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rsp_d;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  potreg_nv_bank #(
    .DW         (DW),
    .NT         (NT),
    .NUM_SLOT   (NUM_SLOT),
    .NUM_WIPER  (NUM_CH),
    .WIPER_INIT (WIPER_INIT),
    .CTRL_INIT  (CTRL_INIT)
  ) u_bank (
    .clk   (clk),
    .we    (nv_we),
    .idx   (cmd_slot),
    .wdata (nv_wd),
    .rdata (nv_rd)
  );

  potreg_store_timer #(
    .CYCLES (BUSY_CYCLES)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (store_go),
    .busy  (busy_w)
  );

  assign busy = busy_w;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      wiper_pos[c]  = vol_q[c];
      ctrl_word[c]  = vol_q[NUM_CH + c];
      comp_pwr[c]   = vol_q[NUM_CH + c][CB_PWR];
      comp_oe[c]    = vol_q[NUM_CH + c][CB_OE];
      comp_latch[c] = vol_q[NUM_CH + c][CB_LATCH];
    end
  end

endmodule

// File: rtl/potreg_checker.sv
module potreg_checker
  import potreg_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = 6,
  parameter int TW     = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wp_n,
  input logic                      cmd_valid,
  input logic                      cmd_ready,
  input logic [3:0]                cmd_op,
  input logic [TW-1:0]             cmd_tgt,
  input logic [DW-1:0]             cmd_data,
  input logic                      rsp_valid,
  input logic                      rsp_ready,
  input logic [DW-1:0]             rsp_data,
  input logic [NUM_CH-1:0][DW-1:0] wiper_pos,
  input logic [NUM_CH-1:0][DW-1:0] ctrl_word,
  input logic                      busy
);

  logic acc;
  assign acc = cmd_valid && cmd_ready;

  p_live_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == OP_LIVE_WR && cmd_tgt == '0) |=> (wiper_pos[0] == $past(cmd_data)));

  p_read_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_op == OP_LIVE_RD || cmd_op == OP_SLOT_RD)) |=> rsp_valid);

  p_store_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wp_n && op_is_store(cmd_op)) |=> busy);

  p_busy_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd_ready);

  p_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !wp_n) |=> !busy);

  p_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !op_is_known(cmd_op)) |=> ($stable(wiper_pos) && $stable(ctrl_word)));

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_rsp_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !cmd_ready);

endmodule

bind dualpot_regexec potreg_checker #(
  .NUM_CH (NUM_CH),
  .DW     (DW),
  .TW     (TW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wp_n      (wp_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_tgt   (cmd_tgt),
  .cmd_data  (cmd_data),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .wiper_pos (wiper_pos),
  .ctrl_word (ctrl_word),
  .busy      (busy)
);

// File: tb/dualpot_regexec_tb.sv
module dualpot_regexec_tb;

  localparam int BUSY = 16;

  typedef struct packed {
    logic [3:0] op;
    logic [1:0] tgt;
    logic [1:0] slot;
    logic [5:0] dat;
    logic       wp;
    logic       chk_rsp;
    logic [5:0] rsp;
    logic [5:0] w0;
    logic [5:0] w1;
    logic [5:0] c0;
    logic [5:0] c1;
    logic [7:0] req;
  } vec_t;

  // op, tgt, slot, data, wp_n, check rsp, rsp, expected w0, w1, c0, c1, requirement
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{4'b1010, 2'd0, 2'd0, 6'h05, 1'b1, 1'b0, 6'h00, 6'h05, 6'h20, 6'h03, 6'h03, 8'd2},  // R2 wiper 0
    '{4'b1010, 2'd3, 2'd0, 6'h2A, 1'b1, 1'b0, 6'h00, 6'h05, 6'h20, 6'h03, 6'h2A, 8'd2},  // R2 control 1
    '{4'b1001, 2'd3, 2'd0, 6'h00, 1'b1, 1'b1, 6'h2A, 6'h05, 6'h20, 6'h03, 6'h2A, 8'd3},  // R3
    '{4'b1100, 2'd1, 2'd2, 6'h11, 1'b1, 1'b0, 6'h00, 6'h05, 6'h20, 6'h03, 6'h2A, 8'd4},  // R4 slot write
    '{4'b1011, 2'd1, 2'd2, 6'h00, 1'b1, 1'b1, 6'h11, 6'h05, 6'h20, 6'h03, 6'h2A, 8'd4},  // R4 slot read
    '{4'b1101, 2'd1, 2'd2, 6'h00, 1'b1, 1'b0, 6'h00, 6'h05, 6'h11, 6'h03, 6'h2A, 8'd5},  // R5 load
    '{4'b1110, 2'd0, 2'd3, 6'h00, 1'b1, 1'b0, 6'h00, 6'h05, 6'h11, 6'h03, 6'h2A, 8'd5},  // R5 store
    '{4'b1010, 2'd0, 2'd0, 6'h3F, 1'b1, 1'b0, 6'h00, 6'h3F, 6'h11, 6'h03, 6'h2A, 8'd2},  // R2 full scale
    '{4'b1101, 2'd0, 2'd3, 6'h00, 1'b1, 1'b0, 6'h00, 6'h05, 6'h11, 6'h03, 6'h2A, 8'd5},  // R5 reload
    '{4'b1000, 2'd2, 2'd1, 6'h00, 1'b1, 1'b0, 6'h00, 6'h05, 6'h11, 6'h03, 6'h2A, 8'd6},  // R6 global store
    '{4'b1010, 2'd2, 2'd0, 6'h00, 1'b1, 1'b0, 6'h00, 6'h05, 6'h11, 6'h00, 6'h2A, 8'd2},  // R2 control 0
    '{4'b0001, 2'd3, 2'd1, 6'h00, 1'b1, 1'b0, 6'h00, 6'h05, 6'h11, 6'h03, 6'h2A, 8'd6},  // R6 global load
    '{4'b0010, 2'd0, 2'd0, 6'h09, 1'b1, 1'b0, 6'h00, 6'h05, 6'h11, 6'h03, 6'h2A, 8'd9},  // R9
    '{4'b1111, 2'd1, 2'd1, 6'h3F, 1'b1, 1'b0, 6'h00, 6'h05, 6'h11, 6'h03, 6'h2A, 8'd9},  // R9
    '{4'b1100, 2'd2, 2'd0, 6'h15, 1'b0, 1'b0, 6'h00, 6'h05, 6'h11, 6'h03, 6'h2A, 8'd8},  // R8 protected
    '{4'b1011, 2'd2, 2'd0, 6'h00, 1'b1, 1'b1, 6'h03, 6'h05, 6'h11, 6'h03, 6'h2A, 8'd8},  // R8 readback
    '{4'b0001, 2'd0, 2'd0, 6'h00, 1'b1, 1'b0, 6'h00, 6'h20, 6'h20, 6'h03, 6'h03, 8'd6},  // R6 slot 0
    '{4'b1100, 2'd0, 2'd0, 6'h07, 1'b1, 1'b0, 6'h00, 6'h20, 6'h20, 6'h03, 6'h03, 8'd4},  // R4
    '{4'b1100, 2'd3, 2'd0, 6'h05, 1'b1, 1'b0, 6'h00, 6'h20, 6'h20, 6'h03, 6'h03, 8'd4}   // R4
  };

  logic            clk = 1'b0;
  logic            rst_n;
  logic            wp_n;
  logic            cmd_valid;
  logic            cmd_ready;
  logic [3:0]      cmd_op;
  logic [1:0]      cmd_tgt;
  logic [1:0]      cmd_slot;
  logic [5:0]      cmd_data;
  logic            rsp_valid;
  logic            rsp_ready;
  logic [5:0]      rsp_data;
  logic [1:0][5:0] wiper_pos;
  logic [1:0][5:0] ctrl_word;
  logic [1:0]      comp_pwr;
  logic [1:0]      comp_oe;
  logic [1:0]      comp_latch;
  logic            busy;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dualpot_regexec #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk (clk), .rst_n (rst_n), .wp_n (wp_n),
    .cmd_valid (cmd_valid), .cmd_ready (cmd_ready), .cmd_op (cmd_op),
    .cmd_tgt (cmd_tgt), .cmd_slot (cmd_slot), .cmd_data (cmd_data),
    .rsp_valid (rsp_valid), .rsp_ready (rsp_ready), .rsp_data (rsp_data),
    .wiper_pos (wiper_pos), .ctrl_word (ctrl_word), .comp_pwr (comp_pwr),
    .comp_oe (comp_oe), .comp_latch (comp_latch), .busy (busy)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive on falling edges; returns on the falling edge after the accepting edge
  task automatic send(input logic [3:0] op, input logic [1:0] tgt,
                      input logic [1:0] slot, input logic [5:0] dat);
    cmd_op = op; cmd_tgt = tgt; cmd_slot = slot; cmd_data = dat;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || rsp_valid) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; wp_n = 1'b1; cmd_valid = 1'b0; rsp_ready = 1'b1;
    cmd_op = '0; cmd_tgt = '0; cmd_slot = '0; cmd_data = '0;
    repeat (4) @(negedge clk);
    // R1 first power-up values come from initial slot contents
    check("R1 reset w0", 32'(wiper_pos[0]), 32'h20);
    check("R1 reset w1", 32'(wiper_pos[1]), 32'h20);
    check("R1 reset c0", 32'(ctrl_word[0]), 32'h03);
    check("R1 reset c1", 32'(ctrl_word[1]), 32'h03);
    check("R7 reset busy", 32'(busy), 32'h0);
    check("R10 reset rsp_valid", 32'(rsp_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      wp_n = VECS[i].wp;
      send(VECS[i].op, VECS[i].tgt, VECS[i].slot, VECS[i].dat);
      check({tag, " w0"}, 32'(wiper_pos[0]), 32'(VECS[i].w0));
      check({tag, " w1"}, 32'(wiper_pos[1]), 32'(VECS[i].w1));
      check({tag, " c0"}, 32'(ctrl_word[0]), 32'(VECS[i].c0));
      check({tag, " c1"}, 32'(ctrl_word[1]), 32'(VECS[i].c1));
      if (VECS[i].chk_rsp) begin
        check({tag, " rsp_valid"}, 32'(rsp_valid), 32'h1);
        check({tag, " rsp_data"}, 32'(rsp_data), 32'(VECS[i].rsp));
      end
      wp_n = 1'b1;
      wait_idle();
    end

    // R7 busy window length and stall
    send(4'b1100, 2'd1, 2'd3, 6'h2B);
    check("R7 ready low while busy", 32'(cmd_ready), 32'h0);
    n = busy ? 1 : 0;
    while (busy) begin
      @(negedge clk);
      if (busy) n++;
    end
    check("R7 busy length", 32'(n), 32'(BUSY));

    // R8 protected store: no busy, slot keeps old value
    wp_n = 1'b0;
    send(4'b1100, 2'd1, 2'd3, 6'h01);
    check("R8 no busy under protect", 32'(busy), 32'h0);
    wp_n = 1'b1;
    send(4'b1011, 2'd1, 2'd3, 6'h00);
    check("R8 slot unchanged", 32'(rsp_data), 32'h2B);
    wait_idle();

    // R10 response held under back-pressure
    rsp_ready = 1'b0;
    send(4'b1001, 2'd0, 2'd0, 6'h00);
    for (int k = 0; k < 3; k++) begin
      check("R10 rsp held valid", 32'(rsp_valid), 32'h1);
      check("R10 rsp data", 32'(rsp_data), 32'h20);
      check("R10 cmd stalled", 32'(cmd_ready), 32'h0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R10 rsp released", 32'(rsp_valid), 32'h0);

    // R1 recall from slot 0 after reset, R11 control bit decode
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 recall w0", 32'(wiper_pos[0]), 32'h07);
    check("R1 recall w1", 32'(wiper_pos[1]), 32'h20);
    check("R1 recall c0", 32'(ctrl_word[0]), 32'h03);
    check("R1 recall c1", 32'(ctrl_word[1]), 32'h05);
    check("R11 comp_pwr", 32'(comp_pwr), 32'h3);
    check("R11 comp_oe", 32'(comp_oe), 32'h1);
    check("R11 comp_latch", 32'(comp_latch), 32'h2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule